// File: doc/BRIEF.md
# PCIe Configuration-Load Sequencer

This block drives the register handshake that loads a device image over PCIe. It reaches a vendor register set through a simple single-outstanding register master port. Through that port it reads the status word, updates the mode-control and program-control words by read-modify-write, and issues bursts of dummy data writes. A single command runs the whole flow in order: the entry checks, the bring-up sequence, a handoff to a separate payload streamer, then teardown and the completion checks. The block ends with one result code.

Status polling uses a retry budget for each phase. The spacing between polls comes from a tick counter derived from the clock frequency. Each time the block reads the status word it also reports the device condition it sees. The image options are latched when the command is accepted, and they set the clocks-per-word ratio used for the payload.

Top module: `pcie_cfg_seq`

## Requirements
- R1: After reset, `seq_done`, `bus_req` and `xfer_go` are 0, and `dev_state` is 0 (unknown).
- R2: A command with `img_partial` set completes with code 4 (invalid argument) and makes no register access.
- R3: If status bit 20 (mode enabled) reads 0, the command ends with code 1 (no device) after exactly one status read (address 0x21C) and no writes.
- R4: Bring-up sets mode-control (0x220) bit 1 (clock select) in one write and then bit 0 (configuration mode) in a separate later write. After the first dummy burst, program-control (0x22C) bit 0 (request) is set.
- R5: Each dummy burst first writes the mode-control ratio field (bits 15:8) to 1, with the other bits unchanged. It then issues exactly 244 writes of value 0 to the data register (0x228).
- R6: After the second burst, program-control bit 1 (start transfer) is set. The ratio field is then loaded with 8 for a compressed image, 4 for an encrypted uncompressed image and 1 otherwise. Only after that is `xfer_go` raised, and it is held until `xfer_fin`.
- R7: Teardown clears program-control bit 1, then clears bit 0 in a separate write, then runs a dummy burst, then polls until status bit 18 (ready) is 0.
- R8: The ready handshakes allow a 10 µs budget, which is one status read. If status bit 18 never becomes 1 after the request, the command ends with code 2 (timeout) after that single read.
- R9: After the completion teardown, the block reads 0x234. If bit 5 is set, the command ends with code 3 (protocol error) and makes no further writes.
- R10: Completion clears mode-control bits 0 and 1 in one write. It then polls until status bits 21 and 24 are both 1, with a 2000 µs budget of 200 reads one poll interval apart. It ends with code 0 on success and code 2 on expiry.
- R11: On every status read, `dev_state` becomes 2 if bit 23 is set, otherwise 1 if bit 20 is set, otherwise 0.
- R12: If status bit 18 is already 1 at the entry check, a full teardown runs before the clock-select write.
- R13: `bus_req` with its address and direction stays stable until `bus_ack`, and drops in the cycle after `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start a full load command (taken when idle) |
| img_compressed | input | 1 | Image is compressed |
| img_encrypted | input | 1 | Image is encrypted |
| img_partial | input | 1 | Partial-reconfiguration request (rejected) |
| seq_done | output | 1 | One-cycle pulse when the command ends |
| seq_code | output | 3 | Result: 0 ok, 1 no device, 2 timeout, 3 protocol, 4 invalid |
| dev_state | output | 2 | 0 unknown, 1 power-up, 2 operating |
| xfer_go | output | 1 | Payload streamer may run |
| xfer_fin | input | 1 | Payload streamer finished |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |

## Verification
The assertions assume a register slave that raises `bus_ack` for one cycle at least one cycle after a request, never acks without a request, and answers each request once. They also assume that `xfer_fin` arrives only while `xfer_go` is high. The bench slave acks exactly one cycle after it sees an unacknowledged request. The streamer stand-in pulses `xfer_fin` for one cycle only after it has seen `xfer_go`. Status bits are produced from the slave's own register contents: ready follows the request bit or is held at 0, and the user-mode pair appears once both mode bits are clear. This keeps every poll outcome consistent with the writes the sequencer has already made.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam logic [31:0] A_STAT = 32'h0000_021C;
    localparam logic [31:0] A_MODE = 32'h0000_0220;
    localparam logic [31:0] A_DATA = 32'h0000_0228;
    localparam logic [31:0] A_PROG = 32'h0000_022C;
    localparam logic [31:0] A_UERR = 32'h0000_0234;

    localparam int ST_RDY  = 18;
    localparam int ST_EN   = 20;
    localparam int ST_USER = 21;
    localparam int ST_DONE = 23;
    localparam int ST_FCLK = 24;
    localparam int MD_CFG  = 0;
    localparam int MD_CLK  = 1;
    localparam int PG_REQ  = 0;
    localparam int PG_XFER = 1;
    localparam int UE_LAT  = 5;
    localparam logic [31:0] RATIO_MASK = 32'h0000_FF00;

    typedef enum logic [2:0] {RC_OK, RC_NODEV, RC_TIMEOUT, RC_PROTO, RC_INVAL} res_e;
    typedef enum logic [1:0] {DS_UNKNOWN, DS_POWERUP, DS_OPERATING} dstate_e;
    typedef enum logic [2:0] {K_NONE, K_RMW, K_POLL, K_FILL, K_CHKEN, K_CHKERR, K_STREAM} kind_e;
    typedef enum logic [2:0] {PH_GO, PH_RD, PH_WGO, PH_WR, PH_TICK} phase_e;
    typedef enum logic [4:0] {
        ST_IDLE, ST_CHKEN,
        TD_XFER, TD_REQ, TD_RATIO, TD_FILL, TD_WAIT,
        SU_CLK, SU_MODE, SU_RATIO1, SU_FILL1, SU_REQ, SU_WAIT,
        SU_RATIO2, SU_FILL2, SU_XFER, SU_PAY, SU_STREAM,
        CP_ERR, CP_CLR, CP_USER
    } step_e;

    typedef struct packed {
        kind_e       kind;
        logic [31:0] addr;
        logic [31:0] clr;
        logic [31:0] set;
        logic [31:0] pmask;
        logic [31:0] pval;
    } op_t;

    function automatic logic [7:0] pay_ratio(logic compressed, logic encrypted);
        if (compressed) return 8'd8;
        if (encrypted)  return 8'd4;
        return 8'd1;
    endfunction

    function automatic dstate_e status_to_state(logic [31:0] s);
        if (s[ST_DONE]) return DS_OPERATING;
        if (s[ST_EN])   return DS_POWERUP;
        return DS_UNKNOWN;
    endfunction

    function automatic step_e next_step(step_e s, logic tear_start);
        case (s)
            ST_CHKEN:  return SU_CLK;
            TD_XFER:   return TD_REQ;
            TD_REQ:    return TD_RATIO;
            TD_RATIO:  return TD_FILL;
            TD_FILL:   return TD_WAIT;
            TD_WAIT:   return tear_start ? SU_CLK : CP_ERR;
            SU_CLK:    return SU_MODE;
            SU_MODE:   return SU_RATIO1;
            SU_RATIO1: return SU_FILL1;
            SU_FILL1:  return SU_REQ;
            SU_REQ:    return SU_WAIT;
            SU_WAIT:   return SU_RATIO2;
            SU_RATIO2: return SU_FILL2;
            SU_FILL2:  return SU_XFER;
            SU_XFER:   return SU_PAY;
            SU_PAY:    return SU_STREAM;
            SU_STREAM: return TD_XFER;
            CP_ERR:    return CP_CLR;
            CP_CLR:    return CP_USER;
            default:   return ST_IDLE;
        endcase
    endfunction

    function automatic op_t decode_step(step_e s, logic [7:0] r);
        op_t o;
        o.kind  = K_NONE;
        o.addr  = A_STAT;
        o.clr   = '0;
        o.set   = '0;
        o.pmask = '0;
        o.pval  = '0;
        case (s)
            ST_CHKEN: o.kind = K_CHKEN;
            TD_XFER: begin o.kind = K_RMW; o.addr = A_PROG; o.clr = 32'(1) << PG_XFER; end
            TD_REQ:  begin o.kind = K_RMW; o.addr = A_PROG; o.clr = 32'(1) << PG_REQ; end
            TD_RATIO, SU_RATIO1, SU_RATIO2: begin
                o.kind = K_RMW; o.addr = A_MODE; o.clr = RATIO_MASK; o.set = 32'h0000_0100;
            end
            TD_FILL, SU_FILL1, SU_FILL2: begin o.kind = K_FILL; o.addr = A_DATA; end
            TD_WAIT: begin o.kind = K_POLL; o.pmask = 32'(1) << ST_RDY; end
            SU_CLK:  begin o.kind = K_RMW; o.addr = A_MODE; o.set = 32'(1) << MD_CLK; end
            SU_MODE: begin o.kind = K_RMW; o.addr = A_MODE; o.set = 32'(1) << MD_CFG; end
            SU_REQ:  begin o.kind = K_RMW; o.addr = A_PROG; o.set = 32'(1) << PG_REQ; end
            SU_WAIT: begin o.kind = K_POLL; o.pmask = 32'(1) << ST_RDY; o.pval = 32'(1) << ST_RDY; end
            SU_XFER: begin o.kind = K_RMW; o.addr = A_PROG; o.set = 32'(1) << PG_XFER; end
            SU_PAY:  begin o.kind = K_RMW; o.addr = A_MODE; o.clr = RATIO_MASK; o.set = {16'h0, r, 8'h0}; end
            SU_STREAM: o.kind = K_STREAM;
            CP_ERR:  begin o.kind = K_CHKERR; o.addr = A_UERR; end
            CP_CLR:  begin o.kind = K_RMW; o.addr = A_MODE; o.clr = 32'h0000_0003; end
            CP_USER: begin
                o.kind  = K_POLL;
                o.pmask = (32'(1) << ST_USER) | (32'(1) << ST_FCLK);
                o.pval  = (32'(1) << ST_USER) | (32'(1) << ST_FCLK);
            end
            default: o.kind = K_NONE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/cfgseq_tick.sv
module cfgseq_tick #(
    parameter int TICK_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    logic [TW-1:0] cnt;

    assign tick = !clr && (cnt == TW'(TICK_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
    import cfgseq_pkg::*;
#(
    parameter int BURST_LEN = 244,
    parameter int RDY_TRIES = 1,
    parameter int USR_TRIES = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_go,
    input  logic        img_compressed,
    input  logic        img_encrypted,
    input  logic        img_partial,
    input  logic        tick,
    output logic        tick_clr,
    output logic        seq_done,
    output logic [2:0]  seq_code,
    output logic [1:0]  dev_state,
    output logic        xfer_go,
    input  logic        xfer_fin,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    localparam int CW = $clog2(BURST_LEN + 1);
    localparam int TW = $clog2(RDY_TRIES + USR_TRIES + 1);

    step_e          step;
    phase_e         ph;
    logic           tear_start;
    logic [7:0]     ratio;
    logic [CW-1:0]  fill_cnt;
    logic [TW-1:0]  tries;
    op_t            op;
    step_e          nxt;
    logic [TW-1:0]  nxt_tries;

    assign op        = decode_step(step, ratio);
    assign nxt       = next_step(step, tear_start);
    assign nxt_tries = (nxt == CP_USER) ? TW'(USR_TRIES) : TW'(RDY_TRIES);
    assign tick_clr  = (ph != PH_TICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE; ph <= PH_GO; tear_start <= 1'b0; ratio <= 8'd1;
            fill_cnt <= '0; tries <= '0; seq_done <= 1'b0; seq_code <= RC_OK;
            dev_state <= DS_UNKNOWN; xfer_go <= 1'b0; bus_req <= 1'b0;
            bus_we <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
        end else begin
            seq_done <= 1'b0;
            if (step == ST_IDLE) begin
                if (cmd_go) begin
                    if (img_partial) begin
                        seq_done <= 1'b1; seq_code <= RC_INVAL;
                    end else begin
                        ratio <= pay_ratio(img_compressed, img_encrypted);
                        tear_start <= 1'b0; step <= ST_CHKEN; ph <= PH_GO;
                    end
                end
            end else begin
                case (ph)
                    PH_GO: begin
                        case (op.kind)
                            K_FILL: begin
                                bus_req <= 1'b1; bus_we <= 1'b1;
                                bus_addr <= op.addr; bus_wdata <= '0; ph <= PH_WR;
                            end
                            K_STREAM: begin
                                xfer_go <= 1'b1;
                                if (xfer_go && xfer_fin) begin
                                    xfer_go <= 1'b0; tear_start <= 1'b0;
                                    step <= nxt; tries <= nxt_tries;
                                end
                            end
                            default: begin
                                bus_req <= 1'b1; bus_we <= 1'b0;
                                bus_addr <= op.addr; ph <= PH_RD;
                            end
                        endcase
                    end
                    PH_RD: if (bus_ack) begin
                        bus_req <= 1'b0;
                        if (op.addr == A_STAT) dev_state <= status_to_state(bus_rdata);
                        case (op.kind)
                            K_RMW: begin
                                bus_wdata <= (bus_rdata & ~op.clr) | op.set;
                                ph <= PH_WGO;
                            end
                            K_POLL: begin
                                if ((bus_rdata & op.pmask) == op.pval) begin
                                    if (step == CP_USER) begin
                                        step <= ST_IDLE; seq_done <= 1'b1; seq_code <= RC_OK;
                                    end else begin
                                        step <= nxt; tries <= nxt_tries;
                                    end
                                    ph <= PH_GO;
                                end else if (tries <= TW'(1)) begin
                                    step <= ST_IDLE; ph <= PH_GO;
                                    seq_done <= 1'b1; seq_code <= RC_TIMEOUT;
                                end else begin
                                    tries <= tries - TW'(1); ph <= PH_TICK;
                                end
                            end
                            K_CHKEN: begin
                                ph <= PH_GO;
                                if (!bus_rdata[ST_EN]) begin
                                    step <= ST_IDLE; seq_done <= 1'b1; seq_code <= RC_NODEV;
                                end else if (bus_rdata[ST_RDY]) begin
                                    tear_start <= 1'b1; step <= TD_XFER;
                                end else begin
                                    step <= nxt; tries <= nxt_tries;
                                end
                            end
                            default: begin
                                ph <= PH_GO;
                                if (bus_rdata[UE_LAT]) begin
                                    step <= ST_IDLE; seq_done <= 1'b1; seq_code <= RC_PROTO;
                                end else begin
                                    step <= nxt; tries <= nxt_tries;
                                end
                            end
                        endcase
                    end
                    PH_WGO: begin
                        bus_req <= 1'b1; bus_we <= 1'b1; ph <= PH_WR;
                    end
                    PH_WR: if (bus_ack) begin
                        bus_req <= 1'b0; ph <= PH_GO;
                        if (op.kind == K_FILL && fill_cnt != CW'(BURST_LEN - 1)) begin
                            fill_cnt <= fill_cnt + CW'(1);
                        end else begin
                            fill_cnt <= '0; step <= nxt; tries <= nxt_tries;
                        end
                    end
                    default: if (tick) ph <= PH_GO;
                endcase
            end
        end
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R13
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_req);

    // R6
    stream_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> !bus_req);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    // R3
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> (!bus_req && !xfer_go));
endmodule

// File: rtl/pcie_cfg_seq.sv
module pcie_cfg_seq #(
    parameter int CLK_MHZ    = 250,
    parameter int POLL_US    = 10,
    parameter int RDY_TMO_US = 10,
    parameter int USR_TMO_US = 2000,
    parameter int BURST_LEN  = 244
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_go,
    input  logic        img_compressed,
    input  logic        img_encrypted,
    input  logic        img_partial,
    output logic        seq_done,
    output logic [2:0]  seq_code,
    output logic [1:0]  dev_state,
    output logic        xfer_go,
    input  logic        xfer_fin,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    localparam int TICK_CYC  = CLK_MHZ * POLL_US;
    localparam int RDY_TRIES = (RDY_TMO_US + POLL_US - 1) / POLL_US;
    localparam int USR_TRIES = (USR_TMO_US + POLL_US - 1) / POLL_US;

    logic tick;
    logic tick_clr;

    cfgseq_tick #(.TICK_CYC(TICK_CYC)) tick_i (
        .clk(clk), .rst(rst), .clr(tick_clr), .tick(tick)
    );

    cfgseq_ctrl #(
        .BURST_LEN(BURST_LEN), .RDY_TRIES(RDY_TRIES), .USR_TRIES(USR_TRIES)
    ) ctrl_i (
        .clk(clk), .rst(rst), .cmd_go(cmd_go),
        .img_compressed(img_compressed), .img_encrypted(img_encrypted),
        .img_partial(img_partial), .tick(tick), .tick_clr(tick_clr),
        .seq_done(seq_done), .seq_code(seq_code), .dev_state(dev_state),
        .xfer_go(xfer_go), .xfer_fin(xfer_fin),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );
endmodule

// File: tb/pcie_cfg_seq_tb_top.sv
module pcie_cfg_seq_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic cmd_go = 0, img_c = 0, img_e = 0, img_p = 0, xfer_fin = 0;
    logic seq_done, xfer_go, bus_req, bus_we, bus_ack;
    logic [2:0] seq_code;
    logic [1:0] dev_state;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    pcie_cfg_seq #(.CLK_MHZ(1)) dut_i (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .img_compressed(img_c),
        .img_encrypted(img_e), .img_partial(img_p), .seq_done(seq_done),
        .seq_code(seq_code), .dev_state(dev_state), .xfer_go(xfer_go),
        .xfer_fin(xfer_fin), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    // register slave model
    logic en_f = 1, cd_f = 0, user_ok = 1, rdy_stuck = 0;
    logic [31:0] prog_init = 0, err_init = 0;
    logic [31:0] s_mode, s_prog, s_err, stat;
    int n_stat_rd, n_acc;

    always_comb begin
        stat = '0;
        stat[20] = en_f;
        stat[18] = rdy_stuck ? 1'b0 : s_prog[0];
        stat[23] = cd_f;
        stat[21] = user_ok && (s_mode[1:0] == 2'b00);
        stat[24] = user_ok && (s_mode[1:0] == 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack <= 0; bus_rdata <= 0; s_mode <= 0; s_prog <= prog_init;
            s_err <= err_init; n_stat_rd <= 0; n_acc <= 0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1; n_acc <= n_acc + 1;
            if (bus_we) begin
                if (bus_addr == 32'h220) s_mode <= bus_wdata;
                if (bus_addr == 32'h22C) s_prog <= bus_wdata;
            end else begin
                case (bus_addr)
                    32'h21C: begin bus_rdata <= stat; n_stat_rd <= n_stat_rd + 1; end
                    32'h220: bus_rdata <= s_mode;
                    32'h22C: bus_rdata <= s_prog;
                    32'h234: bus_rdata <= s_err;
                    default: bus_rdata <= 0;
                endcase
            end
        end else begin
            bus_ack <= 0;
        end
    end

    // scoreboard
    logic [31:0] exp_a[$];
    logic [31:0] exp_d[$];
    string       exp_t[$];
    int n_cmp = 0, n_bad = 0, proto_err = 0;
    logic pv_req = 0, pv_ack = 0, pv_we = 0;
    logic [31:0] pv_addr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pv_req = 0; pv_ack = 0;
        end else begin
            if (pv_req && !pv_ack && (!bus_req || bus_addr != pv_addr || bus_we != pv_we)) proto_err++;
            if (pv_ack && bus_req) proto_err++;
            if (bus_req && !bus_ack && bus_we) begin
                if (exp_a.size() == 0) begin
                    chk(0, "unexpected write", bus_addr, 0);
                end else begin
                    logic [31:0] ea, ed;
                    string et;
                    ea = exp_a.pop_front(); ed = exp_d.pop_front(); et = exp_t.pop_front();
                    chk(bus_addr == ea, et, bus_addr, ea);
                    chk(bus_wdata == ed, et, bus_wdata, ed);
                end
            end
            pv_req = bus_req; pv_ack = bus_ack; pv_addr = bus_addr; pv_we = bus_we;
        end
    end

    task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input string t);
        exp_a.push_back(a); exp_d.push_back(d); exp_t.push_back(t);
    endtask

    task automatic exp_burst(input logic [31:0] m, input string t);
        exp_wr(32'h220, (m & ~32'hFF00) | 32'h100, t);
        for (int i = 0; i < 244; i++) exp_wr(32'h228, 32'h0, "R5");
    endtask

    task automatic exp_start(input logic [31:0] m0, input logic [7:0] r);
        exp_wr(32'h220, m0 | 32'h2, "R4");
        exp_wr(32'h220, m0 | 32'h3, "R4");
        exp_burst(m0 | 32'h3, "R5");
        exp_wr(32'h22C, 32'h1, "R4");
        exp_burst(32'h103, "R5");
        exp_wr(32'h22C, 32'h3, "R6");
        exp_wr(32'h220, {16'h0, r, 8'h03}, "R6");
    endtask

    task automatic exp_tear(input logic [31:0] p, input logic [31:0] m);
        exp_wr(32'h22C, p & ~32'h2, "R7");
        exp_wr(32'h22C, p & ~32'h3, "R7");
        exp_burst(m, "R7");
    endtask

    task automatic setup(input logic en, input logic cd, input logic uok,
                         input logic stuck, input logic [31:0] pinit, input logic [31:0] einit);
        @(negedge clk);
        en_f = en; cd_f = cd; user_ok = uok; rdy_stuck = stuck;
        prog_init = pinit; err_init = einit; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic c, input logic e, input logic p);
        img_c = c; img_e = e; img_p = p; cmd_go = 1;
        @(negedge clk);
        cmd_go = 0;
    endtask

    task automatic wait_done();
        while (!seq_done) @(negedge clk);
    endtask

    task automatic stream(input logic [7:0] r, input string tag);
        while (!xfer_go && !seq_done) @(negedge clk);
        chk(xfer_go, tag, {31'h0, xfer_go}, 1);
        chk(exp_a.size() == 0, tag, exp_a.size(), 0);
        exp_tear(32'h3, {16'h0, r, 8'h03});
        xfer_fin = 1;
        @(negedge clk);
        xfer_fin = 0;
    endtask

    int base;

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!seq_done && !bus_req && !xfer_go, "R1", {29'h0, seq_done, bus_req, xfer_go}, 0);
        chk(dev_state == 2'd0, "R1", dev_state, 0);

        // R2 partial request rejected
        setup(1, 0, 1, 0, 0, 0);
        run_cmd(0, 0, 1);
        wait_done();
        chk(seq_code == 3'd4, "R2", seq_code, 4);
        chk(n_acc == 0, "R2", n_acc, 0);

        // R3 mode disabled, R11 unknown state
        setup(0, 0, 1, 0, 0, 0);
        run_cmd(0, 0, 0);
        wait_done();
        chk(seq_code == 3'd1, "R3", seq_code, 1);
        chk(n_stat_rd == 1 && n_acc == 1, "R3", n_acc, 1);
        chk(dev_state == 2'd0, "R11", dev_state, 0);

        // full compressed load: R4 R5 R6 R7 R10 R11
        setup(1, 1, 1, 0, 0, 0);
        exp_start(32'h0, 8'd8);
        run_cmd(1, 1, 0);
        stream(8'd8, "R6");
        base = n_stat_rd;
        exp_wr(32'h220, 32'h100, "R10");
        wait_done();
        chk(seq_code == 3'd0, "R10", seq_code, 0);
        chk(n_stat_rd - base == 2, "R10", n_stat_rd - base, 2);
        chk(exp_a.size() == 0, "R7", exp_a.size(), 0);
        chk(dev_state == 2'd2, "R11", dev_state, 2);

        // ready already set: R12 teardown first, encrypted ratio 4
        setup(1, 0, 1, 0, 32'h1, 0);
        exp_tear(32'h1, 32'h0);
        exp_start(32'h100, 8'd4);
        run_cmd(0, 1, 0);
        stream(8'd4, "R12");
        exp_wr(32'h220, 32'h100, "R10");
        wait_done();
        chk(seq_code == 3'd0, "R12", seq_code, 0);
        chk(dev_state == 2'd1, "R11", dev_state, 1);

        // ready never rises: R8
        setup(1, 0, 1, 1, 0, 0);
        exp_wr(32'h220, 32'h2, "R4");
        exp_wr(32'h220, 32'h3, "R4");
        exp_burst(32'h3, "R5");
        exp_wr(32'h22C, 32'h1, "R8");
        run_cmd(0, 0, 0);
        wait_done();
        chk(seq_code == 3'd2, "R8", seq_code, 2);
        chk(n_stat_rd == 2, "R8", n_stat_rd, 2);
        chk(exp_a.size() == 0, "R8", exp_a.size(), 0);

        // latched error: R9
        setup(1, 0, 1, 0, 0, 32'h20);
        exp_start(32'h0, 8'd1);
        run_cmd(0, 0, 0);
        stream(8'd1, "R9");
        wait_done();
        chk(seq_code == 3'd3, "R9", seq_code, 3);
        repeat (20) @(negedge clk);
        chk(exp_a.size() == 0, "R9", exp_a.size(), 0);

        // user mode never reached: R10 timeout after 200 polls
        setup(1, 0, 0, 0, 0, 0);
        exp_start(32'h0, 8'd1);
        run_cmd(0, 0, 0);
        stream(8'd1, "R10");
        base = n_stat_rd;
        exp_wr(32'h220, 32'h100, "R10");
        wait_done();
        chk(seq_code == 3'd2, "R10", seq_code, 2);
        chk(n_stat_rd - base == 201, "R10", n_stat_rd - base, 201);

        // R13 bus handshake
        chk(proto_err == 0, "R13", proto_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule